// File: doc/BRIEF.md
# HDLC Frame Serial Transmitter

This block turns a stream of frame bytes into a serial HDLC bit stream. Bytes arrive on a parallel port with a valid/ready handshake and a marker on the final byte of each frame. The block wraps every frame in flag patterns, appends a 16-bit frame check sequence, and inserts a zero after every run of five ones so that frame contents can never look like a flag. It moves one line bit per cycle in which the bit enable is high, so a slower line rate is set by pulsing the enable.

When no frame is waiting, the line carries back-to-back flags. A configuration input sets how consecutive frames are separated. In one setting, a single flag both closes one frame and opens the next. In the other, a closing flag is always followed by a separate opening flag. The address, control and information bytes are all treated as frame content. The block does not decode them, so an address field of one to four bytes needs no setting here.

Top module: `hdlc_tx_serial`

## Requirements
- R1: While reset is asserted, tx_bit is 1 and in_ready is 1. The first eight bits after reset form one complete flag, sent as 0,1,1,1,1,1,1,0 (the byte 7Eh, least significant bit first).
- R2: While no frame byte is held, the line sends complete flags one after another.
- R3: Frame bytes go out least significant bit first, one bit per enabled cycle. tx_bit changes only in the cycle after a cycle with bit_en high.
- R4: The check sequence is a 16-bit CRC with polynomial 1021h and preset FFFFh. It is computed over the frame bits in line order: the feedback is bit 15 XOR the line bit, and the register shifts left. The ones' complement of the result is sent most significant bit first.
- R5: After five consecutive ones in the frame bytes or the check sequence, a 0 is inserted. This includes a run that ends on the last check-sequence bit. No zero is inserted inside a flag.
- R6: When cfg_shared_flag is 1 and the next frame's first byte is held before the closing flag ends, exactly one flag separates the two frames.
- R7: When cfg_shared_flag is 0, every closing flag is followed by at least one further full flag before the next frame's first bit.
- R8: in_ready is 1 exactly when the block's single byte slot is empty. A byte is taken in any cycle with in_valid and in_ready both high, and in_ready is 0 in the next cycle.
- R9: A frame's first bit is sent only directly after a complete flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Advance the line by one bit in this cycle |
| cfg_shared_flag | input | 1 | 1: one flag between frames; 0: separate closing and opening flags |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | The byte is the last of its frame |
| in_ready | output | 1 | The byte slot can take a byte |
| tx_bit | output | 1 | Serial line bit |

## Verification
tx_bit is a register, so the bit for an enabled cycle appears one clock after that cycle. The bench steps its reference model at the falling edge before each rising edge. It then compares tx_bit against the model at the next falling edge, one full period later. A flag or frame decision depends on whether a byte is held before the edge. The model reads this from in_ready at the same falling edge that the design sees at the following rising edge. in_ready must read low at the first falling edge after an accepted byte, and it is checked there.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [1:0] {
    SEG_FLAG = 2'd0,
    SEG_DATA = 2'd1,
    SEG_FCS  = 2'd2
  } seg_e;

  localparam int          FLAG_W   = 8;
  localparam logic [7:0]  FLAG_PAT = 8'h7E;

endpackage

// File: rtl/hdlc_tx_slot.sv
module hdlc_tx_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              take,
  output logic              slot_vld,
  output logic [DATA_W-1:0] slot_data,
  output logic              slot_last
);

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              last_q, last_d;

  always_comb begin
    vld_d  = vld_q;
    data_d = data_q;
    last_d = last_q;
    if (take) begin
      vld_d = 1'b0;
    end
    if (in_valid && !vld_q) begin
      vld_d  = 1'b1;
      data_d = in_data;
      last_d = in_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
      last_q <= last_d;
    end
  end

  assign in_ready  = !vld_q;
  assign slot_vld  = vld_q;
  assign slot_data = data_q;
  assign slot_last = last_q;

  // R8: an accepted byte fills the slot for at least the next cycle
  a_r8_slot_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready)
    else $error("accepted byte did not occupy the slot");

  // R8: the sequencer only drains a full slot
  a_r8_take_full: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> vld_q)
    else $error("byte taken from an empty slot");

endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
  parameter int              FCS_W = 16,
  parameter logic [FCS_W-1:0] POLY  = 16'h1021,
  parameter logic [FCS_W-1:0] SEED  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             restart,
  input  logic             din,
  output logic [FCS_W-1:0] fcs_o
);

  logic [FCS_W-1:0] crc_q, crc_d, base;
  logic             fb;

  always_comb begin
    base  = restart ? SEED : crc_q;
    fb    = base[FCS_W-1] ^ din;
    crc_d = crc_q;
    if (upd) begin
      crc_d = {base[FCS_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= SEED;
    end else begin
      crc_q <= crc_d;
    end
  end

  assign fcs_o = crc_q;

  // R4: the register only moves on a frame bit
  a_r4_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(fcs_o))
    else $error("check register changed without a frame bit");

endmodule

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic emit,
  input  logic region,
  input  logic bit_i,
  output logic pend_o
);

  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] ones_q, ones_d;
  logic          pend_q, pend_d;

  always_comb begin
    ones_d = ones_q;
    pend_d = pend_q;
    if (step && pend_q) begin
      pend_d = 1'b0;
      ones_d = '0;
    end else if (emit) begin
      if (region && bit_i) begin
        if (ones_q == CW'(RUN_LEN - 1)) begin
          pend_d = 1'b1;
          ones_d = '0;
        end else begin
          ones_d = ones_q + CW'(1);
        end
      end else begin
        ones_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      pend_q <= 1'b0;
    end else begin
      ones_q <= ones_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R5: an inserted zero occupies exactly one line slot
  a_r5_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pend_o) |=> !pend_o)
    else $error("stuffed zero pending for more than one slot");

  // R5: flag bits never count toward a run
  a_r5_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !region) |=> (ones_q == '0) && !pend_o)
    else $error("run counted across a flag bit");

endmodule

// File: rtl/hdlc_tx_serial.sv
module hdlc_tx_serial
  import hdlc_tx_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter int              FCS_W    = 16,
  parameter logic [FCS_W-1:0] FCS_POLY = 16'h1021,
  parameter logic [FCS_W-1:0] FCS_SEED = 16'hFFFF,
  parameter int              RUN_LEN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              cfg_shared_flag,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              tx_bit
);

  localparam int SH_W0 = (FCS_W > DATA_W) ? FCS_W : DATA_W;
  localparam int SH_W  = (SH_W0 > FLAG_W) ? SH_W0 : FLAG_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  seg_e             seg_q, seg_d, cur_seg;
  logic [SH_W-1:0]  sh_q, sh_d, cur_sh;
  logic [CNT_W-1:0] left_q, left_d, cur_left;
  logic             last_q, last_d, last_sel;
  logic             extra_q, extra_d, extra_sel;
  logic             tx_q, tx_d;

  logic              slot_vld, slot_last;
  logic [DATA_W-1:0] slot_data;
  logic              take_sel, take_w, restart_sel, stall, go, region;
  logic              stuff_pend, crc_upd;
  logic [FCS_W-1:0]  fcs_val, fcs_rev;

  hdlc_tx_slot #(.DATA_W(DATA_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .take     (take_w),
    .slot_vld (slot_vld),
    .slot_data(slot_data),
    .slot_last(slot_last)
  );

  // symbol selection: when the shifter is empty, pick what goes out next
  always_comb begin
    for (int i = 0; i < FCS_W; i++) begin
      fcs_rev[i] = ~fcs_val[FCS_W-1-i];
    end
    cur_seg     = seg_q;
    cur_sh      = sh_q;
    cur_left    = left_q;
    take_sel    = 1'b0;
    restart_sel = 1'b0;
    stall       = 1'b0;
    last_sel    = last_q;
    extra_sel   = extra_q;
    if (left_q == '0) begin
      case (seg_q)
        SEG_DATA: begin
          if (last_q) begin
            cur_seg  = SEG_FCS;
            cur_sh   = SH_W'(fcs_rev);
            cur_left = CNT_W'(FCS_W);
          end else if (slot_vld) begin
            cur_seg  = SEG_DATA;
            cur_sh   = SH_W'(slot_data);
            cur_left = CNT_W'(DATA_W);
            take_sel = 1'b1;
            last_sel = slot_last;
          end else begin
            stall = 1'b1;
          end
        end
        SEG_FCS: begin
          cur_seg   = SEG_FLAG;
          cur_sh    = SH_W'(FLAG_PAT);
          cur_left  = CNT_W'(FLAG_W);
          extra_sel = !cfg_shared_flag;
        end
        default: begin
          if (!extra_q && slot_vld) begin
            cur_seg     = SEG_DATA;
            cur_sh      = SH_W'(slot_data);
            cur_left    = CNT_W'(DATA_W);
            take_sel    = 1'b1;
            restart_sel = 1'b1;
            last_sel    = slot_last;
          end else begin
            cur_seg   = SEG_FLAG;
            cur_sh    = SH_W'(FLAG_PAT);
            cur_left  = CNT_W'(FLAG_W);
            extra_sel = 1'b0;
          end
        end
      endcase
    end
    go      = bit_en && !stuff_pend && !stall;
    region  = (cur_seg != SEG_FLAG);
    take_w  = go && take_sel;
    crc_upd = go && (cur_seg == SEG_DATA);
  end

  hdlc_tx_fcs #(.FCS_W(FCS_W), .POLY(FCS_POLY), .SEED(FCS_SEED)) u_fcs (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (crc_upd),
    .restart(restart_sel),
    .din    (cur_sh[0]),
    .fcs_o  (fcs_val)
  );

  hdlc_tx_stuff #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (bit_en),
    .emit  (go),
    .region(region),
    .bit_i (cur_sh[0]),
    .pend_o(stuff_pend)
  );

  // next state
  always_comb begin
    seg_d   = seg_q;
    sh_d    = sh_q;
    left_d  = left_q;
    last_d  = last_q;
    extra_d = extra_q;
    tx_d    = tx_q;
    if (go) begin
      seg_d   = cur_seg;
      sh_d    = cur_sh >> 1;
      left_d  = cur_left - CNT_W'(1);
      last_d  = last_sel;
      extra_d = extra_sel;
      tx_d    = cur_sh[0];
    end else if (bit_en && stuff_pend) begin
      tx_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q   <= SEG_FLAG;
      sh_q    <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
      extra_q <= 1'b1;
      tx_q    <= 1'b1;
    end else begin
      seg_q   <= seg_d;
      sh_q    <= sh_d;
      left_q  <= left_d;
      last_q  <= last_d;
      extra_q <= extra_d;
      tx_q    <= tx_d;
    end
  end

  assign tx_bit = tx_q;

  // R3: the line only moves after an enabled cycle
  a_r3_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit))
    else $error("tx_bit moved without bit_en");

  // R5: a pending insertion puts a zero on the line
  a_r5_stuff_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_pend) |=> !tx_bit)
    else $error("inserted bit was not zero");

  // R2: an empty slot at a flag boundary keeps the line in flags
  a_r2_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !stuff_pend && seg_q == SEG_FLAG && left_q == '0 && !slot_vld)
      |=> (seg_q == SEG_FLAG))
    else $error("left the flag sequence with no byte held");

  // R9: a frame opens only once a flag has fully gone out
  a_r9_open_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && seg_q == SEG_FLAG) |-> (left_q == '0) && !extra_q)
    else $error("frame started inside or before a flag");

endmodule

// File: tb/test_hdlc_tx_serial.sv
module test_hdlc_tx_serial;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic       cfg_shared_flag;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_last;
  logic       in_ready;
  logic       tx_bit;

  always #10 clk = ~clk;

  hdlc_tx_serial i_hdlc_tx_serial (
    .clk            (clk),
    .rst_n          (rst_n),
    .bit_en         (bit_en),
    .cfg_shared_flag(cfg_shared_flag),
    .in_data        (in_data),
    .in_valid       (in_valid),
    .in_last        (in_last),
    .in_ready       (in_ready),
    .tx_bit         (tx_bit)
  );

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  logic [7:0] byte_a [0:31];
  bit         last_a [0:31];
  int nbytes = 0;
  int upto   = 0;
  int idx    = 0;
  bit fire_prev = 1'b0;
  bit en_every  = 1'b1;

  // reference model state
  bit exp_q[$];
  int tag_q[$];
  bit exp_bit  = 1'b1;
  int exp_tag  = 1;
  bit m_extra  = 1'b1;
  bit m_first  = 1'b1;
  int m_ones   = 0;
  int mf       = 0;

  function automatic string tname(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic void push_bit(bit b, int t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endfunction

  function automatic void push_flag(int t);
    logic [7:0] f = 8'h7E;
    for (int i = 0; i < 8; i++) push_bit(f[i], t);
  endfunction

  function automatic void push_body(bit b, int t);
    push_bit(b, t);
    if (b) m_ones++; else m_ones = 0;
    if (m_ones == 5) begin
      push_bit(1'b0, 5);
      m_ones = 0;
    end
  endfunction

  function automatic void push_frame();
    logic [15:0] crc = 16'hFFFF;
    logic [15:0] fcs;
    bit fb;
    bit first = 1'b1;
    bit done  = 1'b0;
    int p = mf;
    m_ones = 0;
    while (!done) begin
      for (int b = 0; b < 8; b++) begin
        bit v = byte_a[p][b];
        push_body(v, first ? 9 : 3);
        first = 1'b0;
        fb  = crc[15] ^ v;
        crc = {crc[14:0], 1'b0};
        if (fb) crc = crc ^ 16'h1021;
      end
      if (last_a[p]) done = 1'b1;
      p++;
    end
    mf  = p;
    fcs = ~crc;
    for (int i = 15; i >= 0; i--) push_body(fcs[i], 4);
    push_flag(cfg_shared_flag ? 6 : 7);
    m_extra = !cfg_shared_flag;
  endfunction

  task automatic add_frame(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3,
                           input logic [7:0] b4, input int len);
    logic [7:0] v [0:4];
    v[0] = b0; v[1] = b1; v[2] = b2; v[3] = b3; v[4] = b4;
    for (int k = 0; k < len; k++) begin
      byte_a[nbytes] = v[k];
      last_a[nbytes] = (k == len - 1);
      nbytes++;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog: run hung, idx=%0d expected %0d", idx, upto);
      summary();
      $finish;
    end
    if (rst_n === 1'b1) begin
      checks++;
      if (tx_bit !== exp_bit) begin
        errors++;
        $display("FAIL %s: tx_bit=%0b expected %0b (cycle %0d)",
                 tname(exp_tag), tx_bit, exp_bit, cyc);
      end
      if (fire_prev) begin
        checks++;
        if (in_ready !== 1'b0) begin
          errors++;
          $display("FAIL R8: in_ready=%0b expected 0 after accept", in_ready);
        end
        idx++;
      end
      bit_en   = en_every ? 1'b1 : ((cyc % 3) == 0);
      in_valid = (idx < upto);
      in_data  = in_valid ? byte_a[idx] : 8'h00;
      in_last  = in_valid ? last_a[idx] : 1'b0;
      fire_prev = in_valid && in_ready;
      if (bit_en) begin
        if (exp_q.size() == 0) begin
          if (m_extra) begin
            push_flag(m_first ? 1 : 7);
            m_first = 1'b0;
            m_extra = 1'b0;
          end else if (!in_ready) begin
            push_frame();
          end else begin
            push_flag(2);
          end
        end
        exp_bit = exp_q.pop_front();
        exp_tag = tag_q.pop_front();
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    bit_en = 1'b0;
    in_valid = 1'b0;
    in_data = 8'h00;
    in_last = 1'b0;
    cfg_shared_flag = 1'b1;
    add_frame(8'h03, 8'h3F, 8'h00, 8'h00, 8'h00, 2);
    add_frame(8'hFF, 8'h13, 8'h7E, 8'hFF, 8'hF0, 5);
    add_frame(8'h01, 8'h00, 8'hA5, 8'h5A, 8'hC3, 5);
    add_frame(8'h11, 8'h22, 8'h33, 8'h00, 8'h00, 3);
    add_frame(8'h7E, 8'h7E, 8'h00, 8'h00, 8'h00, 2);
    add_frame(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 4);
    repeat (3) @(negedge clk);
    checks++;
    if (tx_bit !== 1'b1) begin
      errors++;
      $display("FAIL R1: tx_bit=%0b expected 1 in reset", tx_bit);
    end
    checks++;
    if (in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: in_ready=%0b expected 1 in reset", in_ready);
    end
    rst_n = 1'b1;
    repeat (40) @(negedge clk);          // reset flag then idle flags (R1, R2)
    upto = 12;                            // shared-flag frames, full rate (R6)
    wait (idx == upto);
    repeat (400) @(negedge clk);
    cfg_shared_flag = 1'b0;               // separate flags, 1-in-3 rate (R7)
    en_every = 1'b0;
    repeat (5) @(negedge clk);
    upto = nbytes;
    wait (idx == upto);
    repeat (900) @(negedge clk);
    summary();
    $finish;
  end

endmodule